// File: doc/BRIEF.md
# Y-Extended Saturating Integer Divider

This block is a multi-cycle integer divider for a processor execute stage. It has two operand sets. In the 32-bit set the dividend is 64 bits wide: a separate 32-bit Y value forms the upper word and the low word of the first operand forms the lower word. The divisor is 32 bits wide. The quotient must fit in 32 bits. A quotient that does not fit is clamped to a fixed limit and is not wrapped. In the 64-bit set two full 64-bit operands are divided and Y plays no part. Each set has an unsigned form and a signed form. Each of the four forms may also produce condition flags.

The issuing stage raises `start` for one cycle while the block is idle. The block then holds `busy` while it works. One quotient bit is resolved per cycle by restoring division on operand magnitudes, and `done` is raised for a single cycle when the result is ready. The second operand can come from a register value or from a 13-bit immediate, which is sign-extended. A zero divisor ends the operation early with a divide-by-zero indication, and no result is written.

Top module: `divYSat`

## Requirements
- R1: When `wideMode`=0, the dividend is {`yIn`, `opA`[31:0]} and the divisor is bits 31:0 of the selected second operand. The upper bits of `opB` are ignored.
- R2: In 32-bit unsigned mode, a quotient above 0xFFFFFFFF is returned as 0x00000000FFFFFFFF. A quotient of exactly 0xFFFFFFFF is returned unchanged.
- R3: In 32-bit signed mode, a quotient above 0x7FFFFFFF returns 0x000000007FFFFFFF. A quotient below -2^31 returns 0xFFFFFFFF80000000. Any other quotient is returned sign-extended to 64 bits, and this includes exactly -2^31.
- R4: Signed division truncates toward zero. The quotient is negative exactly when the signs of the dividend and the divisor differ.
- R5: When `useImm`=1, the second operand is `imm` sign-extended to 64 bits and `opB` is ignored.
- R6: A divisor of zero, tested after the R1/R5 selection, ends the operation with `done` and `divZero` high together. `quotient` keeps its previous value and `flagsValid` stays low.
- R7: When `wideMode`=1, the full 64-bit `opA` is divided by the full 64-bit second operand and `yIn` is ignored. In signed form, -2^63 divided by -1 returns 0x8000000000000000.
- R8: When `setFlags`=1, `flagsValid` pulses together with `done`. N and Z are taken from bits 31:0 of the result in 32-bit mode and from all 64 bits in 64-bit mode. V is the R2/R3 saturation condition and is always 0 in 64-bit mode. C is 0.
- R9: `start` is accepted only while `busy` is low. `busy` holds for at most 65 cycles. `done` is high for exactly one cycle per accepted start. A `start` raised while `busy` is high has no effect.
- R10: `quotient` changes only in a cycle where `done` is high. The N/Z/V outputs change only when `flagsValid` is high, so an operation with `setFlags`=0 leaves them as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (used only when idle) |
| wideMode | input | 1 | 1: 64-bit operand set, 0: Y-extended 32-bit set |
| signedOp | input | 1 | 1: signed division |
| setFlags | input | 1 | 1: produce N/Z/V/C |
| useImm | input | 1 | 1: second operand is the immediate |
| imm | input | 13 | Signed immediate |
| opA | input | 64 | First operand |
| opB | input | 64 | Second operand |
| yIn | input | 32 | Upper dividend word for the 32-bit set |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| divZero | output | 1 | Divide-by-zero, valid with done |
| quotient | output | 64 | Last written quotient |
| flagsValid | output | 1 | Flags updated this cycle |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |
| flagV | output | 1 | Saturation flag |
| flagC | output | 1 | Carry flag, always 0 |

## Verification
Completion of one operation and a new `start` can arrive in the same cycle. In that cycle the final state is still busy, so the new request must be dropped and must not start a second operation. The bench drives `start` exactly in the completion cycle, and also in the middle of an iteration. In both cases it pairs the request with a zero-divisor operand that would produce a fast, distinctive extra `done`. It judges the result by requiring that exactly one completion arrives, with the quotient of the original operation, and that no unexpected completion reaches the scoreboard afterwards.

// File: rtl/divPkg.sv
package divPkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } divState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;    // capture operands, clear partial remainder
    logic step;    // resolve one quotient bit
    logic commit;  // write quotient (and flags) from the finished run
  } divCtrl_t;
endpackage

// File: rtl/divOperands.sv
// Operand selection, divisor zero test and magnitude conversion (combinational).
module divOperands #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 13,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic              wideMode,
  input  logic              signedOp,
  input  logic              useImm,
  input  logic [IMM_W-1:0]  imm,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [HALF_W-1:0] yIn,
  output logic [DATA_W-1:0] dvdMag,
  output logic [DATA_W-1:0] dsrMag,
  output logic              quoNeg,
  output logic              divisorZero
);
  logic [DATA_W-1:0] srcB;
  logic [DATA_W-1:0] dvdRaw;
  logic [DATA_W-1:0] dsrRaw;
  logic              dvdNeg;
  logic              dsrNeg;

  always_comb begin
    srcB = useImm ? {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm} : opB;
    if (wideMode) begin
      dvdRaw = opA;
      dsrRaw = srcB;
    end else begin
      dvdRaw = {yIn, opA[HALF_W-1:0]};
      dsrRaw = signedOp ? {{HALF_W{srcB[HALF_W-1]}}, srcB[HALF_W-1:0]}
                        : {{HALF_W{1'b0}}, srcB[HALF_W-1:0]};
    end
    dvdNeg      = signedOp & dvdRaw[DATA_W-1];
    dsrNeg      = signedOp & dsrRaw[DATA_W-1];
    dvdMag      = dvdNeg ? -dvdRaw : dvdRaw;
    dsrMag      = dsrNeg ? -dsrRaw : dsrRaw;
    quoNeg      = dvdNeg ^ dsrNeg;
    divisorZero = (dsrRaw == '0);
  end
endmodule

// File: rtl/divCtrl.sv
// Sequencer: idle / iterate / finish, with the completion pulse.
module divCtrl
  import divPkg::*;
#(
  parameter int DATA_W = 64,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     divisorZero,
  output divCtrl_t ctrl,
  output logic     busy,
  output logic     done,
  output logic     divZero
);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(DATA_W - 1);

  divState_t       state;
  logic [CNT_W-1:0] stepCnt;
  logic            zeroHit;

  always_comb begin
    ctrl.load   = (state == ST_IDLE) && start;
    ctrl.step   = (state == ST_RUN);
    ctrl.commit = (state == ST_FIN) && !zeroHit;
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      zeroHit <= 1'b0;
      done    <= 1'b0;
      divZero <= 1'b0;
    end else begin
      done    <= (state == ST_FIN);
      divZero <= (state == ST_FIN) && zeroHit;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            zeroHit <= divisorZero;
            stepCnt <= '0;
            state   <= divisorZero ? ST_FIN : ST_RUN;
          end
        end
        ST_RUN: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == LAST_STEP) state <= ST_FIN;
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/divDatapath.sv
// Restoring-division datapath plus result sign, saturation and flags.
module divDatapath
  import divPkg::*;
#(
  parameter int DATA_W = 64,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  divCtrl_t          ctrl,
  input  logic [DATA_W-1:0] dvdMag,
  input  logic [DATA_W-1:0] dsrMag,
  input  logic              quoNeg,
  input  logic              wideMode,
  input  logic              signedOp,
  input  logic              setFlags,
  output logic [DATA_W-1:0] quotient,
  output logic              flagsValid,
  output logic              flagN,
  output logic              flagZ,
  output logic              flagV
);
  localparam logic [DATA_W-1:0] SAT_U = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
  localparam logic [DATA_W-1:0] SAT_P = {{(HALF_W+1){1'b0}}, {(HALF_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] SAT_N = {{(HALF_W+1){1'b1}}, {(HALF_W-1){1'b0}}};

  logic [DATA_W-1:0] remR, quoR, dsrR;
  logic              negR, wideR, sgnR, setFR;

  // one restoring step
  logic [DATA_W:0]   shifted;
  logic              borrow;
  logic [DATA_W-1:0] diff;

  always_comb begin
    shifted = {remR, quoR[DATA_W-1]};
    borrow  = shifted < {1'b0, dsrR};
    diff    = shifted[DATA_W-1:0] - dsrR;
  end

  // result shaping
  logic [DATA_W-1:0] qSigned, result;
  logic              hiNz, posOver, negUnder, unsOver, sat;
  logic              resN, resZ;

  always_comb begin
    qSigned  = negR ? -quoR : quoR;
    hiNz     = |quoR[DATA_W-1:HALF_W];
    unsOver  = !sgnR && hiNz;
    posOver  = sgnR && !negR && (|quoR[DATA_W-1:HALF_W-1]);
    negUnder = sgnR && negR && (hiNz || (quoR[HALF_W-1] && (|quoR[HALF_W-2:0])));
    if (wideR) begin
      sat    = 1'b0;
      result = qSigned;
      resN   = result[DATA_W-1];
      resZ   = (result == '0);
    end else begin
      sat = unsOver || posOver || negUnder;
      if (unsOver)       result = SAT_U;
      else if (posOver)  result = SAT_P;
      else if (negUnder) result = SAT_N;
      else               result = qSigned;
      resN = result[HALF_W-1];
      resZ = (result[HALF_W-1:0] == '0);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remR  <= '0;
      quoR  <= '0;
      dsrR  <= '0;
      negR  <= 1'b0;
      wideR <= 1'b0;
      sgnR  <= 1'b0;
      setFR <= 1'b0;
    end else if (ctrl.load) begin
      remR  <= '0;
      quoR  <= dvdMag;
      dsrR  <= dsrMag;
      negR  <= quoNeg;
      wideR <= wideMode;
      sgnR  <= signedOp;
      setFR <= setFlags;
    end else if (ctrl.step) begin
      if (borrow) begin
        remR <= shifted[DATA_W-1:0];
        quoR <= {quoR[DATA_W-2:0], 1'b0};
      end else begin
        remR <= diff;
        quoR <= {quoR[DATA_W-2:0], 1'b1};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quotient   <= '0;
      flagsValid <= 1'b0;
      flagN      <= 1'b0;
      flagZ      <= 1'b0;
      flagV      <= 1'b0;
    end else begin
      flagsValid <= ctrl.commit && setFR;
      if (ctrl.commit) begin
        quotient <= result;
        if (setFR) begin
          flagN <= resN;
          flagZ <= resZ;
          flagV <= sat;
        end
      end
    end
  end
endmodule

// File: rtl/divYSat.sv
module divYSat
  import divPkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 13,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              wideMode,
  input  logic              signedOp,
  input  logic              setFlags,
  input  logic              useImm,
  input  logic [IMM_W-1:0]  imm,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [HALF_W-1:0] yIn,
  output logic              busy,
  output logic              done,
  output logic              divZero,
  output logic [DATA_W-1:0] quotient,
  output logic              flagsValid,
  output logic              flagN,
  output logic              flagZ,
  output logic              flagV,
  output logic              flagC
);
  divCtrl_t          ctrl;
  logic [DATA_W-1:0] dvdMag, dsrMag;
  logic              quoNeg, divisorZero;

  divOperands #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_ops (
    .wideMode(wideMode), .signedOp(signedOp), .useImm(useImm), .imm(imm),
    .opA(opA), .opB(opB), .yIn(yIn),
    .dvdMag(dvdMag), .dsrMag(dsrMag), .quoNeg(quoNeg), .divisorZero(divisorZero)
  );

  divCtrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .divisorZero(divisorZero),
    .ctrl(ctrl), .busy(busy), .done(done), .divZero(divZero)
  );

  divDatapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .dvdMag(dvdMag), .dsrMag(dsrMag), .quoNeg(quoNeg),
    .wideMode(wideMode), .signedOp(signedOp), .setFlags(setFlags),
    .quotient(quotient), .flagsValid(flagsValid),
    .flagN(flagN), .flagZ(flagZ), .flagV(flagV)
  );

  assign flagC = 1'b0;
endmodule

// File: rtl/divYSat_chk.sv
module divYSat_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              divZero,
  input logic              flagsValid,
  input logic [DATA_W-1:0] quotient
);
  localparam int BUSY_MAX = DATA_W + 1;

  logic [$clog2(BUSY_MAX+2)-1:0] busyRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1'b1;
    else           busyRun <= '0;
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R9
  start_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);
  // R9
  busy_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= BUSY_MAX);
  // R6
  zero_no_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    divZero |-> (done && !flagsValid));
  // R6
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && divZero) |-> $stable(quotient));
  // R10
  quotient_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(quotient));
endmodule

bind divYSat divYSat_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .divZero(divZero), .flagsValid(flagsValid), .quotient(quotient)
);

// File: tb/divYSat_tb.sv
`timescale 1ns/1ps
module divYSat_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0, wideMode = 1'b0, signedOp = 1'b0, setFlags = 1'b0, useImm = 1'b0;
  logic [12:0] imm = '0;
  logic [63:0] opA = '0, opB = '0;
  logic [31:0] yIn = '0;
  logic        busy, done, divZero, flagsValid, flagN, flagZ, flagV, flagC;
  logic [63:0] quotient;

  always #2 clk = ~clk;

  divYSat u_dut (
    .clk(clk), .rstN(rstN), .start(start), .wideMode(wideMode), .signedOp(signedOp),
    .setFlags(setFlags), .useImm(useImm), .imm(imm), .opA(opA), .opB(opB), .yIn(yIn),
    .busy(busy), .done(done), .divZero(divZero), .quotient(quotient),
    .flagsValid(flagsValid), .flagN(flagN), .flagZ(flagZ), .flagV(flagV), .flagC(flagC)
  );

  typedef struct {
    string       tag;
    logic [63:0] q;
    bit          dz;
    bit          fv;
    bit          n, z, v;
  } expItem_t;

  expItem_t expQ[$];
  int compared = 0, mismatched = 0, doneCnt = 0, issued = 0;
  bit finished = 0;
  logic [63:0] lastQ = '0;
  bit lastN = 0, lastZ = 0, lastV = 0;

  task automatic check(input string tag, input string what, input bit ok,
                       input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual 0x%016h expected 0x%016h", tag, what, act, exp);
    end
  endtask

  // independent reference model
  function automatic expItem_t model(input string tag, input bit wide, sgn, setF, ui,
                                     input logic [12:0] im, input logic [63:0] a, b,
                                     input logic [31:0] y);
    expItem_t e;
    logic [63:0] src, res;
    logic signed [127:0] sd, sv, sq;
    logic [127:0] ud, uq;
    bit sat;
    e.tag = tag;
    src = ui ? {{51{im[12]}}, im} : b;
    sat = 0;
    res = '0;
    e.dz = wide ? (src == 0) : (src[31:0] == 0);
    if (!e.dz) begin
      if (wide && !sgn) res = a / src;
      else if (wide) begin
        sd = {{64{a[63]}}, a};
        sv = {{64{src[63]}}, src};
        sq = sd / sv;
        res = sq[63:0];
      end else if (!sgn) begin
        ud = {64'd0, y, a[31:0]};
        uq = ud / {96'd0, src[31:0]};
        if (uq > 128'hFFFFFFFF) begin sat = 1; res = 64'h00000000FFFFFFFF; end
        else res = uq[63:0];
      end else begin
        sd = {{64{y[31]}}, y, a[31:0]};
        sv = {{96{src[31]}}, src[31:0]};
        sq = sd / sv;
        if (sq > 128'sh7FFFFFFF) begin sat = 1; res = 64'h000000007FFFFFFF; end
        else if (sq < -(128'sh80000000)) begin sat = 1; res = 64'hFFFFFFFF80000000; end
        else res = sq[63:0];
      end
    end
    e.q  = res;
    e.fv = setF && !e.dz;
    e.n  = wide ? res[63] : res[31];
    e.z  = wide ? (res == 0) : (res[31:0] == 0);
    e.v  = sat;
    return e;
  endfunction

  // driver: issue one operation, optionally pulse start again while busy
  task automatic runOp(input string tag, input bit wide, sgn, setF, ui,
                       input logic [12:0] im, input logic [63:0] a, b,
                       input logic [31:0] y, input int disturbAt);
    expQ.push_back(model(tag, wide, sgn, setF, ui, im, a, b, y));
    issued++;
    @(negedge clk);
    wideMode = wide; signedOp = sgn; setFlags = setF; useImm = ui;
    imm = im; opA = a; opB = b; yIn = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (disturbAt > 0) begin
      repeat (disturbAt - 1) @(negedge clk);
      wideMode = 1'b0; useImm = 1'b0; opA = 64'd12345; opB = 64'd0; yIn = 32'd7;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (doneCnt == issued);
    @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && done) begin
      if (expQ.size() == 0) begin
        check("R9", "unexpected done", 1'b0, quotient, 64'd0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check(e.tag, "divZero", divZero == e.dz, 64'(divZero), 64'(e.dz));
        check(e.tag, "quotient", quotient == (e.dz ? lastQ : e.q), quotient, e.dz ? lastQ : e.q);
        check(e.tag, "flagsValid", flagsValid == e.fv, 64'(flagsValid), 64'(e.fv));
        if (!e.dz) lastQ = e.q;
        if (e.fv) begin lastN = e.n; lastZ = e.z; lastV = e.v; end
        check(e.tag, "flags NZV", {flagN, flagZ, flagV} == {lastN, lastZ, lastV},
              64'({flagN, flagZ, flagV}), 64'({lastN, lastZ, lastV}));
        check(e.tag, "flagC", flagC == 1'b0, 64'(flagC), 64'd0);
      end
      doneCnt++;
    end
  end

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10", "reset busy", busy == 1'b0, 64'(busy), 64'd0);
    check("R10", "reset done", done == 1'b0, 64'(done), 64'd0);
    check("R10", "reset quotient", quotient == 64'd0, quotient, 64'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1: Y supplies the upper dividend word; upper opB bits ignored
    runOp("R1", 0, 0, 1, 0, 13'd0, 64'h0, 64'd2, 32'd1, 0);
    runOp("R1", 0, 0, 1, 0, 13'd0, 64'hAAAA_0000_0000_0009, 64'hFFFF_FFFF_0000_0003, 32'd0, 0);
    // R2: unsigned saturation and its exact boundary
    runOp("R2", 0, 0, 1, 0, 13'd0, 64'h0, 64'd2, 32'd5, 0);
    runOp("R2", 0, 0, 1, 0, 13'd0, 64'hFFFF_FFFF, 64'd2, 32'd1, 0);
    // R3: signed overflow, underflow, exact minimum
    runOp("R3", 0, 1, 1, 0, 13'd0, 64'h8000_0000, 64'd1, 32'd0, 0);
    runOp("R3", 0, 1, 1, 0, 13'd0, 64'h7FFF_FFFF, 64'd1, 32'hFFFF_FFFF, 0);
    runOp("R3", 0, 1, 1, 0, 13'd0, 64'h8000_0000, 64'd1, 32'hFFFF_FFFF, 0);
    // R4: truncation toward zero, both sign combinations
    runOp("R4", 0, 1, 1, 0, 13'd0, 64'hFFFF_FFF9, 64'd2, 32'hFFFF_FFFF, 0);
    runOp("R4", 0, 1, 1, 0, 13'd0, 64'd7, 64'hFFFF_FFFE, 32'd0, 0);
    runOp("R4", 0, 1, 1, 0, 13'd0, 64'hFFFF_FFF9, 64'hFFFF_FFFE, 32'hFFFF_FFFF, 0);
    // R5: immediate, sign-extended, opB ignored
    runOp("R5", 0, 1, 1, 1, 13'h1FFE, 64'd100, 64'd9, 32'd0, 0);
    runOp("R5", 0, 0, 1, 1, 13'h1FFE, 64'd0, 64'd3, 32'd1, 0);
    // R6: zero divisors, including one hidden in upper opB bits
    runOp("R6", 0, 0, 1, 0, 13'd0, 64'd50, 64'd0, 32'd0, 0);
    runOp("R6", 0, 1, 1, 0, 13'd0, 64'd50, 64'h1_0000_0000, 32'd0, 0);
    runOp("R6", 1, 0, 1, 1, 13'd0, 64'd50, 64'd4, 32'd0, 0);
    // R7: 64-bit set ignores Y; signed minimum by -1
    runOp("R7", 1, 0, 1, 0, 13'd0, 64'h1_0000_0004, 64'h1_0000_0000, 32'hDEAD, 0);
    runOp("R7", 1, 0, 1, 0, 13'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 32'hBEEF, 0);
    runOp("R7", 1, 1, 1, 0, 13'd0, 64'hFFFF_FFFF_FFFF_FF9C, 64'd7, 32'h1234, 0);
    runOp("R7", 1, 1, 1, 0, 13'd0, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 32'd0, 0);
    // R8: zero result in each set; N from bit 31 vs bit 63
    runOp("R8", 0, 0, 1, 0, 13'd0, 64'd1, 64'd2, 32'd0, 0);
    runOp("R8", 1, 0, 1, 0, 13'd0, 64'h8000_0000, 64'd1, 32'd0, 0);
    runOp("R8", 1, 1, 1, 0, 13'd0, 64'd1, 64'd2, 32'd0, 0);
    // R10: no-flag operations leave N/Z/V untouched
    runOp("R10", 0, 0, 0, 0, 13'd0, 64'd0, 64'd2, 32'd9, 0);
    runOp("R10", 1, 1, 0, 0, 13'd0, 64'd0, 64'd5, 32'd0, 0);
    // R9: start while busy mid-run and in the completion cycle is dropped
    runOp("R9", 0, 0, 1, 0, 13'd0, 64'd1000, 64'd10, 32'd0, 10);
    runOp("R9", 1, 0, 1, 0, 13'd0, 64'd77, 64'd7, 32'd0, 65);
    runOp("R9", 0, 1, 0, 0, 13'd0, 64'd81, 64'd9, 32'd0, 0);

    repeat (80) @(negedge clk);
    check("R9", "leftover expected items", expQ.size() == 0, 64'(expQ.size()), 64'd0);
    check("R9", "done count", doneCnt == issued, 64'(doneCnt), 64'(issued));
    finishRun();
  end
endmodule